// File: doc/BRIEF.md
# Differential pixel run encoder

This block compares a freshly drawn frame against the frame currently shown on a panel, one pixel at a time in raster order (left to right, top to bottom, as one flat index from 0 to `FRAME_PIX-1`). From that comparison it builds a short list of changed spans. Each span is a start index and a pixel count. A later uploader can then send only those spans to the display.

Two pixel streams (new frame and shown frame) enter through valid/ready handshakes. A pair is taken only when both sides are valid. A span does not end at the first unchanged pixel. It stays open across short stretches of unchanged pixels and ends only once the number of unchanged pixels in a row reaches a programmable threshold. This keeps the list short when the changes are scattered.

The spans are kept in a small internal log of `LOG_DEPTH` entries. When the frame's last pixel has been taken, they are sent out on a descriptor stream. If the log would overflow, or if the full-frame option is set, the block sends one span that covers the whole frame. A one-cycle done pulse, with an overflow bit beside it, closes every frame.

Top module: `pixdiff_run_enc`

## Requirements
- R1: Pixel pairs are numbered 0 to `FRAME_PIX-1` in the order they are taken, and the index restarts at 0 for the first pair after a done pulse. A span's `run_start` is the index of its first changed pixel.
- R2: A pixel counts as changed only if `(cur_pix ^ prev_pix) & cfg_mask` is nonzero. Differences in bits where `cfg_mask` is 0 are ignored.
- R3: An open span closes when the count of unchanged pixels in a row, counted after its last changed pixel, reaches `cfg_gap`. A shorter unchanged stretch followed by a changed pixel stays inside the same span. A `cfg_gap` of 0 behaves as 1.
- R4: A span's `run_len` runs from its start to its last changed pixel inclusive. The unchanged pixels that closed it are not counted.
- R5: A span that is still open when pixel `FRAME_PIX-1` is taken is closed there.
- R6: With `cfg_full` high for the whole frame, the block sends exactly one span, start 0 and length `FRAME_PIX`, whatever the pixel data.
- R7: If a frame produces more than `LOG_DEPTH` spans, the stored spans are dropped. The block sends one span with start 0 and length `FRAME_PIX`, and `frame_ovf` is 1 during the done pulse. Exactly `LOG_DEPTH` spans is not an overflow.
- R8: A frame with no changed pixel sends no span, and the done pulse still arrives.
- R9: Spans are sent in ascending start order, and only after the frame's last pixel has been taken. While `run_valid` is high and `run_ready` is low, the start and length hold steady. Both pixel ready outputs are low from the frame's last pixel until the done pulse.
- R10: `frame_done` is high for exactly one cycle. That cycle is the one after the last span handshake, or the second cycle after the last pixel when no span is sent.
- R11: Outside that sending window, both ready outputs are high. A pixel pair is taken only on a cycle where `cur_valid` and `prev_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gap | input | GAP_W | Unchanged-pixel count that closes a span (0 acts as 1) |
| cfg_mask | input | PIX_W | Bits of a pixel that take part in the comparison |
| cfg_full | input | 1 | Skip comparison and send the whole frame as one span |
| cur_valid | input | 1 | New-frame pixel valid |
| cur_ready | output | 1 | New-frame pixel ready |
| cur_pix | input | PIX_W | New-frame pixel |
| prev_valid | input | 1 | Shown-frame pixel valid |
| prev_ready | output | 1 | Shown-frame pixel ready |
| prev_pix | input | PIX_W | Shown-frame pixel |
| run_valid | output | 1 | Span descriptor valid |
| run_ready | input | 1 | Span descriptor accepted by the consumer |
| run_start | output | $clog2(FRAME_PIX+1) | Index of the span's first pixel |
| run_len | output | $clog2(FRAME_PIX+1) | Number of pixels in the span |
| frame_done | output | 1 | One-cycle pulse that ends a frame |
| frame_ovf | output | 1 | High during `frame_done` when the log overflowed |

## Verification
The span log is written on the same edge that takes the last pixel. The first descriptor is therefore visible in the cycle right after that edge, and the bench starts watching the descriptor port from that falling edge. The done pulse follows one cycle after the last handshake, or two cycles after the last pixel for an empty frame. The bench counts falling edges from the last pixel to the done pulse and compares that count with these fixed offsets.

Every sample is taken at a falling edge. Inputs change one time step after a rising edge. The bench applies uneven backpressure on `run_ready` and inserts one-sided valid bubbles, so the holding and pairing rules are checked under stalls.

// File: rtl/pixdiff_pkg.sv
package pixdiff_pkg;

    // Phase of the encoder: taking pixels, sending spans, one-cycle done
    typedef enum logic [1:0] {
        PH_SCAN  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

endpackage

// File: rtl/pixdiff_cmp.sv
module pixdiff_cmp #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] cur_pix,
    input  logic [PIX_W-1:0] prev_pix,
    input  logic [PIX_W-1:0] mask,
    output logic             changed
);

    logic [PIX_W-1:0] diff;

    // One lane per pixel bit: a difference counts only where the mask is set
    for (genvar b = 0; b < PIX_W; b++) begin : g_bit
        assign diff[b] = (cur_pix[b] ^ prev_pix[b]) & mask[b];
    end

    assign changed = |diff;

endmodule

// File: rtl/pixdiff_run_track.sv
module pixdiff_run_track #(
    parameter int FRAME_PIX = 64,
    parameter int GAP_W     = 6,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             changed,
    input  logic             force_full,
    input  logic [GAP_W-1:0] gap_cfg,
    output logic             push_valid,
    output logic [LEN_W-1:0] push_start,
    output logic [LEN_W-1:0] push_len,
    output logic             frame_end
);

    localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(FRAME_PIX - 1);

    typedef struct packed {
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] start;
        logic [LEN_W-1:0] last;
        logic [GAP_W-1:0] gap;
        logic             open;
    } trk_t;

    trk_t s_d, s_q;

    logic           hit;
    logic [GAP_W:0] gap_eff;
    logic [GAP_W:0] gap_next;

    assign hit      = changed & ~force_full;
    assign gap_eff  = (gap_cfg == '0) ? (GAP_W+1)'(1) : {1'b0, gap_cfg};
    assign gap_next = {1'b0, s_q.gap} + (GAP_W+1)'(1);

    always_comb begin
        s_d        = s_q;
        push_valid = 1'b0;
        push_start = '0;
        push_len   = '0;
        frame_end  = 1'b0;
        if (accept) begin
            if (hit) begin
                if (!s_q.open) begin
                    s_d.open  = 1'b1;
                    s_d.start = s_q.idx;
                end
                s_d.last = s_q.idx;
                s_d.gap  = '0;
            end else if (s_q.open) begin
                if (gap_next >= gap_eff) begin
                    // enough quiet pixels: close, trailing gap excluded
                    push_valid = 1'b1;
                    push_start = s_q.start;
                    push_len   = s_q.last - s_q.start + LEN_W'(1);
                    s_d.open   = 1'b0;
                    s_d.gap    = '0;
                end else begin
                    s_d.gap = gap_next[GAP_W-1:0];
                end
            end
            if (s_q.idx == LAST_IDX) begin
                frame_end = 1'b1;
                s_d.idx   = '0;
                if (s_d.open) begin
                    push_valid = 1'b1;
                    push_start = s_d.start;
                    push_len   = s_d.last - s_d.start + LEN_W'(1);
                    s_d.open   = 1'b0;
                    s_d.gap    = '0;
                end
            end else begin
                s_d.idx = s_q.idx + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // A closing span never reaches beyond the pixel being taken
    AST_SPAN_BEHIND_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (({1'b0, push_start} + {1'b0, push_len}) <= ({1'b0, s_q.idx} + (LEN_W+1)'(1))))
        else $error("span extends past current pixel"); // R4

    // An open span never holds a quiet count that should have closed it
    AST_GAP_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> ({1'b0, s_q.gap} < gap_eff))
        else $error("gap count reached threshold while open"); // R3

endmodule

// File: rtl/pixdiff_log.sv
module pixdiff_log
    import pixdiff_pkg::*;
#(
    parameter int FRAME_PIX = 64,
    parameter int LOG_DEPTH = 4,
    parameter int LEN_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [LEN_W-1:0] push_start,
    input  logic [LEN_W-1:0] push_len,
    input  logic             frame_end,
    input  logic             force_full,
    output logic             scan_en,
    output logic             run_valid,
    input  logic             run_ready,
    output logic [LEN_W-1:0] run_start,
    output logic [LEN_W-1:0] run_len,
    output logic             frame_done,
    output logic             frame_ovf
);

    localparam int               CNT_W    = $clog2(LOG_DEPTH + 1);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(FRAME_PIX);

    typedef struct packed {
        logic [LEN_W-1:0] start;
        logic [LEN_W-1:0] len;
    } span_t;

    typedef struct packed {
        phase_e                      phase;
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            rd;
        logic                        ovf;
        logic                        full;
        span_t [LOG_DEPTH-1:0]       mem;
    } log_t;

    log_t  s_d, s_q;
    span_t sel;
    logic  fallback;
    logic  has_entry;

    assign fallback  = s_q.ovf | s_q.full;
    assign has_entry = s_q.rd < s_q.cnt;

    always_comb begin
        sel = '0;
        for (int k = 0; k < LOG_DEPTH; k++) begin
            if (CNT_W'(k) == s_q.rd) sel = s_q.mem[k];
        end
    end

    assign scan_en    = (s_q.phase == PH_SCAN);
    assign run_valid  = (s_q.phase == PH_DRAIN) && (fallback || has_entry);
    assign run_start  = fallback ? '0 : sel.start;
    assign run_len    = fallback ? FULL_LEN : sel.len;
    assign frame_done = (s_q.phase == PH_DONE);
    assign frame_ovf  = (s_q.phase == PH_DONE) && s_q.ovf;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_SCAN: begin
                if (push_valid) begin
                    if (s_q.cnt < CNT_W'(LOG_DEPTH)) begin
                        for (int k = 0; k < LOG_DEPTH; k++) begin
                            if (CNT_W'(k) == s_q.cnt) begin
                                s_d.mem[k].start = push_start;
                                s_d.mem[k].len   = push_len;
                            end
                        end
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end else begin
                        s_d.ovf = 1'b1;
                    end
                end
                if (frame_end) begin
                    s_d.full  = force_full;
                    s_d.phase = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                if (fallback) begin
                    if (run_ready) s_d.phase = PH_DONE;
                end else if (!has_entry) begin
                    s_d.phase = PH_DONE;
                end else if (run_ready) begin
                    s_d.rd = s_q.rd + CNT_W'(1);
                    if ((s_q.rd + CNT_W'(1)) == s_q.cnt) s_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                s_d.phase = PH_SCAN;
                s_d.cnt   = '0;
                s_d.rd    = '0;
                s_d.ovf   = 1'b0;
                s_d.full  = 1'b0;
            end
            default: s_d.phase = PH_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_SPAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && !run_ready) |=> (run_valid && $stable(run_start) && $stable(run_len)))
        else $error("descriptor changed while stalled"); // R9

    AST_OVF_SENT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ovf |-> $past(run_valid && run_ready && (run_start == '0) && (run_len == FULL_LEN)))
        else $error("overflow frame did not end with whole-frame span"); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("done longer than one cycle"); // R10

endmodule

// File: rtl/pixdiff_run_enc.sv
module pixdiff_run_enc #(
    parameter int PIX_W     = 8,
    parameter int FRAME_PIX = 64,
    parameter int GAP_W     = 6,
    parameter int LOG_DEPTH = 4,
    localparam int LEN_W    = $clog2(FRAME_PIX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic [PIX_W-1:0] cfg_mask,
    input  logic             cfg_full,
    input  logic             cur_valid,
    output logic             cur_ready,
    input  logic [PIX_W-1:0] cur_pix,
    input  logic             prev_valid,
    output logic             prev_ready,
    input  logic [PIX_W-1:0] prev_pix,
    output logic             run_valid,
    input  logic             run_ready,
    output logic [LEN_W-1:0] run_start,
    output logic [LEN_W-1:0] run_len,
    output logic             frame_done,
    output logic             frame_ovf
);

    logic             scan_en;
    logic             accept;
    logic             changed;
    logic             push_valid;
    logic [LEN_W-1:0] push_start;
    logic [LEN_W-1:0] push_len;
    logic             frame_end;

    assign cur_ready  = scan_en;
    assign prev_ready = scan_en;
    assign accept     = cur_valid & prev_valid & scan_en;

    pixdiff_cmp #(
        .PIX_W (PIX_W)
    ) u_cmp (
        .cur_pix  (cur_pix),
        .prev_pix (prev_pix),
        .mask     (cfg_mask),
        .changed  (changed)
    );

    pixdiff_run_track #(
        .FRAME_PIX (FRAME_PIX),
        .GAP_W     (GAP_W),
        .LEN_W     (LEN_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .changed    (changed),
        .force_full (cfg_full),
        .gap_cfg    (cfg_gap),
        .push_valid (push_valid),
        .push_start (push_start),
        .push_len   (push_len),
        .frame_end  (frame_end)
    );

    pixdiff_log #(
        .FRAME_PIX (FRAME_PIX),
        .LOG_DEPTH (LOG_DEPTH),
        .LEN_W     (LEN_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_start (push_start),
        .push_len   (push_len),
        .frame_end  (frame_end),
        .force_full (cfg_full),
        .scan_en    (scan_en),
        .run_valid  (run_valid),
        .run_ready  (run_ready),
        .run_start  (run_start),
        .run_len    (run_len),
        .frame_done (frame_done),
        .frame_ovf  (frame_ovf)
    );

    // No pixel is taken while spans are waiting to go out
    AST_NO_PIXEL_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |-> (!cur_ready && !prev_ready))
        else $error("pixel ready during span output"); // R9

endmodule

// File: tb/pixdiff_run_enc_bench.sv
module pixdiff_run_enc_bench;

    localparam int NP    = 64;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_gap = '0;
    logic [7:0] cfg_mask = 8'hFF;
    logic       cfg_full = 1'b0;
    logic       cur_valid = 1'b0;
    logic       cur_ready;
    logic [7:0] cur_pix = '0;
    logic       prev_valid = 1'b0;
    logic       prev_ready;
    logic [7:0] prev_pix = '0;
    logic       run_valid;
    logic       run_ready = 1'b0;
    logic [6:0] run_start;
    logic [6:0] run_len;
    logic       frame_done;
    logic       frame_ovf;

    int checks = 0;
    int errors = 0;
    int exp_n;
    bit exp_ovf;
    int exp_s [NP];
    int exp_l [NP];
    int got_s [NP];
    int got_l [NP];

    always #2.5 clk = ~clk;

    pixdiff_run_enc u_pixdiff_run_enc (
        .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .cfg_mask(cfg_mask),
        .cfg_full(cfg_full), .cur_valid(cur_valid), .cur_ready(cur_ready),
        .cur_pix(cur_pix), .prev_valid(prev_valid), .prev_ready(prev_ready),
        .prev_pix(prev_pix), .run_valid(run_valid), .run_ready(run_ready),
        .run_start(run_start), .run_len(run_len), .frame_done(frame_done),
        .frame_ovf(frame_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Expected span list from the span rules
    task automatic build_expected(input logic [NP-1:0] c, input int gap, input bit full);
        int  t;
        int  s;
        int  l;
        int  g;
        bit  open;
        t = (gap == 0) ? 1 : gap;
        exp_n = 0; exp_ovf = 1'b0; open = 1'b0; s = 0; l = 0; g = 0;
        if (full) begin
            exp_n = 1; exp_s[0] = 0; exp_l[0] = NP;
            return;
        end
        for (int i = 0; i < NP; i++) begin
            if (c[i]) begin
                if (!open) begin open = 1'b1; s = i; end
                l = i; g = 0;
            end else if (open) begin
                g++;
                if (g >= t) begin
                    exp_s[exp_n] = s; exp_l[exp_n] = l - s + 1; exp_n++;
                    open = 1'b0; g = 0;
                end
            end
        end
        if (open) begin
            exp_s[exp_n] = s; exp_l[exp_n] = l - s + 1; exp_n++;
        end
        if (exp_n > DEPTH) begin
            exp_n = 1; exp_ovf = 1'b1; exp_s[0] = 0; exp_l[0] = NP;
        end
    endtask

    task automatic run_frame(input logic [NP-1:0] c, input int gap, input logic [7:0] mask,
                             input bit full, input int bubble, input string req);
        logic [7:0] f_in;
        logic [7:0] f_out;
        logic [7:0] old_v;
        int  i;
        int  cyc;
        int  n;
        int  k;
        int  last_hs;
        int  k_done;
        bit  held;
        int  held_s;
        int  held_l;
        bit  rdy_bad;
        build_expected(c, gap, full);
        @(posedge clk); #1;
        cfg_gap = 6'(gap); cfg_mask = mask; cfg_full = full;
        f_in  = mask & (~mask + 8'd1);
        f_out = ~mask;
        i = 0; cyc = 0;
        while (i < NP) begin
            old_v = 8'((i * 37 + 11) & 8'hFF);
            prev_pix = old_v;
            cur_pix  = old_v ^ (c[i] ? (f_in | f_out) : f_out);
            if (bubble != 0 && ((cyc * 7 + bubble) % 5 == 0)) begin
                cur_valid  = cyc[0];
                prev_valid = ~cyc[0];
            end else begin
                cur_valid  = 1'b1;
                prev_valid = 1'b1;
            end
            @(negedge clk);
            if (!(cur_ready && prev_ready))
                check(1'b0, "R11", "pixel ready low during scan", 0, 1);
            @(posedge clk); #1;
            if (cur_valid && prev_valid) i++;
            cyc++;
        end
        cur_valid = 1'b0; prev_valid = 1'b0;
        n = 0; last_hs = -1; k_done = -1; held = 1'b0; held_s = 0; held_l = 0; rdy_bad = 1'b0;
        for (k = 0; k < 400; k++) begin
            @(negedge clk);
            if (frame_done) begin
                k_done = k;
                break;
            end
            if (cur_ready || prev_ready) rdy_bad = 1'b1;
            if (held) begin
                check(run_valid && int'(run_start) == held_s && int'(run_len) == held_l,
                      "R9", "stalled span changed start", int'(run_start), held_s);
            end
            run_ready = ((k % 3) != 2);
            if (run_valid && run_ready && n < NP) begin
                got_s[n] = int'(run_start); got_l[n] = int'(run_len); n++;
                last_hs = k;
            end
            held   = run_valid && !run_ready;
            held_s = int'(run_start);
            held_l = int'(run_len);
            @(posedge clk);
        end
        run_ready = 1'b0;
        check(!rdy_bad, "R9", "pixel ready high while sending", int'(rdy_bad), 0);
        check(n == exp_n, req, "span count", n, exp_n);
        for (int j = 0; j < exp_n && j < n; j++) begin
            check(got_s[j] == exp_s[j], req, "span start", got_s[j], exp_s[j]);
            check(got_l[j] == exp_l[j], req, "span length", got_l[j], exp_l[j]);
        end
        check(frame_ovf == exp_ovf, "R7", "overflow bit at done", int'(frame_ovf), int'(exp_ovf));
        if (exp_n > 0)
            check(k_done == last_hs + 1, "R10", "done cycle after last span", k_done, last_hs + 1);
        else
            check(k_done == 1, "R10", "done cycle for empty frame", k_done, 1);
        @(negedge clk);
        check(!frame_done, "R10", "done pulse width", int'(frame_done), 0);
    endtask

    function automatic logic [NP-1:0] lfsr_pat(input int seed, input int density);
        logic [31:0] r;
        logic [NP-1:0] v;
        r = 32'(seed) | 32'h1;
        v = '0;
        for (int i = 0; i < NP; i++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            v[i] = (int'(r[7:0]) < density);
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NP-1:0] pats [8];
        int gaps [7];
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cur_ready && prev_ready, "R11", "ready after reset", int'(cur_ready), 1);
        check(!run_valid, "R9", "no span after reset", int'(run_valid), 0);
        check(!frame_done, "R10", "no done after reset", int'(frame_done), 0);

        run_frame(64'h0000_0000_0000_00E0, 3, 8'hFF, 1'b0, 0, "R1");
        run_frame(64'h0000_0000_0000_1400, 4, 8'hFF, 1'b0, 0, "R4");
        run_frame(64'h0000_0000_0000_1400, 2, 8'hFF, 1'b0, 0, "R4");
        run_frame(64'hC000_0000_0000_0001, 8, 8'hFF, 1'b0, 0, "R5");
        run_frame(64'h0000_00F0_0F00_0030, 3, 8'hF0, 1'b0, 0, "R2");
        run_frame(64'h0, 1, 8'h0F, 1'b0, 0, "R2");
        run_frame(lfsr_pat(77, 90), 2, 8'hFF, 1'b1, 0, "R6");
        run_frame(64'hAAAA_AAAA_AAAA_AAAA, 1, 8'hFF, 1'b0, 0, "R7");
        run_frame(64'h0000_0040_4010_0401, 2, 8'hFF, 1'b0, 0, "R7");
        run_frame(64'h0000_0100_4010_0401, 2, 8'hFF, 1'b0, 0, "R7");
        run_frame(64'h0, 5, 8'hFF, 1'b0, 0, "R8");
        run_frame(64'h0300_0000_F000_0C01, 4, 8'hFF, 1'b0, 3, "R11");

        pats[0] = 64'h0;
        pats[1] = '1;
        pats[2] = 64'h1;
        pats[3] = 64'h8000_0000_0000_0000;
        pats[4] = 64'h0000_0000_0000_0249;
        pats[5] = 64'h00F0_0110_0000_1C00;
        pats[6] = lfsr_pat(5, 40);
        pats[7] = lfsr_pat(91, 20);
        gaps[0] = 0; gaps[1] = 1; gaps[2] = 2; gaps[3] = 3;
        gaps[4] = 4; gaps[5] = 6; gaps[6] = 40;
        for (int gi = 0; gi < 7; gi++) begin
            for (int p = 0; p < 8; p++) begin
                run_frame(pats[p], gaps[gi], 8'hFF, 1'b0, (p == 5) ? 2 : 0, "R3");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule